// File: doc/BRIEF.md
# Data Memory Bus Cycle Sequencer

This block steps a processor's data memory access through its bus states on a shared address/data bus. After an accepted request, the bus cycle runs through a setup state (T1), an address state (TX) and a final data state (T2). Each bus state lasts two clocks. The first clock is the rising half of the state and the second clock is the falling half.

Wait states can be added at two separate points. Between T1 and TX, hold states (TW) are added while the active-low lock input is low or the remote-busy input is high. Between TX and T2, extension states (TP) are added: first a programmed count of them, then more for as long as the external wait input stays high.

The block drives the address-latch strobe, the bus value and its output enable, and the write and read strobes. For a read it captures the data from the bus at the end of T2. It gives a one-clock done pulse once the access ends.

Top module: `mbs_seq`

## Requirements
- R1: After reset, the strobes `ale_o`, `wr_o`, `rd_o`, `done_o` and `ad_oe_o` are all low, and the block is idle.
- R2: When `req_i` is high while the block is idle, an access is accepted. Each bus state lasts two clocks. With no waits, `done_o` is high in clock 7 after the accepting edge (clock 1 is the first clock after that edge). Each TW or TP state adds 2 clocks.
- R3: The hold condition is true when `lock_n_i` is low or `rmt_busy_i` is high. It is sampled at the middle edge of T1 and of every TW state. A true sample makes the following state a TW; a false sample leads on to TX.
- R4: Throughout T1 and TW, `ale_o` is high and the bus is not driven (`ad_oe_o` low).
- R5: During both clocks of TX, the bus drives the latched address. `ale_o` stays high in the first clock of TX and falls for the second clock.
- R6: The programmed wait count `pwait_i` (0 to 7) is loaded when the access is accepted. It adds exactly that many TP states between TX and T2, counting down one per bus state.
- R7: Once the programmed count is used up, `ext_wait_i` is sampled at the end of TX or TP. While it is high, one further TP state is added. Its waits add to any lock or remote waits.
- R8: For a write (`we_i` = 1), `wr_o` is high for exactly the two clocks of T2. The bus drives the write data, zero-extended, from the first TP (or T2) through the end of T2.
- R9: For a read, `rd_o` is high for the two clocks of T2 and the bus is not driven after TX. `rdata_o` takes the low DATA_W bits of `ad_i` at the final edge of T2.
- R10: `done_o` is a single-clock pulse. A request raised while an access is in progress is ignored: no second access follows, and the first access keeps its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one clock per half bus state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, sampled while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | BUS_W | Access address |
| wdata_i | input | DATA_W | Write data |
| pwait_i | input | WAIT_W | Programmed wait-state count |
| lock_n_i | input | 1 | Active-low lock; low holds the cycle before TX |
| rmt_busy_i | input | 1 | Remote access in progress; high holds the cycle before TX |
| ext_wait_i | input | 1 | External wait; high extends the cycle before T2 |
| ad_i | input | BUS_W | Bus value seen by the block (read data) |
| ale_o | output | 1 | Address-latch strobe |
| ad_o | output | BUS_W | Bus drive value |
| ad_oe_o | output | 1 | Bus output enable |
| wr_o | output | 1 | Write strobe |
| rd_o | output | 1 | Read strobe |
| done_o | output | 1 | One-clock access-complete pulse |
| rdata_o | output | DATA_W | Captured read data |

## Verification
Some rules are checked by assertions on every cycle:
- the state changes only on state boundaries;
- a true hold sample always leads into TW;
- the bus is enabled whenever the address-latch strobe falls;
- the write and read strobes never overlap, with the bus driven for writes and released for reads;
- no T2 begins with programmed waits left;
- the done pulse lasts one clock;
- the latched address stays put when a request arrives mid-access.

Other behaviour only the bench scenarios can show, because it needs exact cycle counts:
- how many TW states a given lock or remote-busy window produces;
- how programmed and external waits add together;
- the clock in which `done_o` rises;
- that the read data is taken at the last edge of T2.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_TW   = 3'd2,
    S_TX   = 3'd3,
    S_TP   = 3'd4,
    S_T2   = 3'd5
  } tstate_e;

  // Hold condition for the pre-address wait point.
  function automatic logic f_hold(input logic lock_n, input logic rmt_busy);
    return (!lock_n) || rmt_busy;
  endfunction

  // Extension decision at the end of TX or TP.
  function automatic logic f_extend(input logic cnt_zero, input logic ext_wait);
    return (!cnt_zero) || ext_wait;
  endfunction

  // Clock index (after accept edge) in which done is high.
  function automatic int f_done_cycle(input int n_tw, input int n_tp);
    return 1 + 2 * (3 + n_tw + n_tp);
  endfunction

endpackage

// File: rtl/mbs_phase.sv
module mbs_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_q,
  output logic state_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   half_q <= 1'b0;
    else if (run) half_q <= ~half_q;
    else          half_q <= 1'b0;
  end

  assign state_end = run && half_q;

  p_half_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !half_q);
endmodule

// File: rtl/mbs_hold.sv
module mbs_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic lock_n,
  input  logic rmt_busy,
  output logic hold_q
);
  import mbs_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= 1'b0;
    else if (sample_en) hold_q <= f_hold(lock_n, rmt_busy);
  end

  p_hold_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !lock_n) |=> hold_q);
endmodule

// File: rtl/mbs_pwait.sv
module mbs_pwait #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              dec,
  output logic              cnt_zero
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (dec && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_zero = (cnt_q == '0);

  p_dec_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !cnt_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/mbs_seq.sv
module mbs_seq #(
  parameter int BUS_W  = 16,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BUS_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WAIT_W-1:0] pwait_i,
  input  logic              lock_n_i,
  input  logic              rmt_busy_i,
  input  logic              ext_wait_i,
  input  logic [BUS_W-1:0]  ad_i,
  output logic              ale_o,
  output logic [BUS_W-1:0]  ad_o,
  output logic              ad_oe_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  import mbs_pkg::*;

  localparam int PAD_W = BUS_W - DATA_W;

  tstate_e            st_q;
  logic               we_q;
  logic [BUS_W-1:0]   addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               half_q, state_end, hold_q, cnt_zero;
  logic               accept, in_hold_zone, at_ext_point, extend, pw_dec;

  assign accept       = (st_q == S_IDLE) && req_i;
  assign in_hold_zone = (st_q == S_T1) || (st_q == S_TW);
  assign at_ext_point = (st_q == S_TX) || (st_q == S_TP);
  assign extend       = f_extend(cnt_zero, ext_wait_i);
  assign pw_dec       = state_end && at_ext_point;

  mbs_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (st_q != S_IDLE),
    .half_q    (half_q),
    .state_end (state_end)
  );

  mbs_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (in_hold_zone && !half_q),
    .lock_n    (lock_n_i),
    .rmt_busy  (rmt_busy_i),
    .hold_q    (hold_q)
  );

  mbs_pwait #(.WAIT_W(WAIT_W)) u_pwait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (pwait_i),
    .dec      (pw_dec),
    .cnt_zero (cnt_zero)
  );

  // State sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else begin
      unique case (st_q)
        S_IDLE: if (accept) st_q <= S_T1;
        S_T1, S_TW: if (state_end) st_q <= hold_q ? S_TW : S_TX;
        S_TX, S_TP: if (state_end) st_q <= extend ? S_TP : S_T2;
        S_T2:   if (state_end) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // Access capture, completion and read data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= (st_q == S_T2) && state_end;
      if (accept) begin
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if ((st_q == S_T2) && state_end && !we_q)
        rdata_o <= ad_i[DATA_W-1:0];
    end
  end

  // Bus and strobe decode
  always_comb begin
    ale_o   = in_hold_zone || ((st_q == S_TX) && !half_q);
    ad_oe_o = (st_q == S_TX) || (we_q && ((st_q == S_TP) || (st_q == S_T2)));
    if (st_q == S_TX) ad_o = addr_q;
    else              ad_o = {{PAD_W{1'b0}}, wdata_q};
    wr_o    = we_q && (st_q == S_T2);
    rd_o    = !we_q && (st_q == S_T2);
  end

  // Assertions
  p_state_on_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != S_IDLE) && !half_q) |=> (st_q == $past(st_q)));

  p_hold_to_tw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold_zone && state_end && hold_q) |=> (st_q == S_TW));

  p_quiet_before_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe_o && ale_o) |-> (st_q == S_TX));

  p_ale_fall_driven_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_o) |-> (ad_oe_o && ad_o == addr_q));

  p_no_early_t2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_T2) |-> cnt_zero);

  p_ext_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_dec && ext_wait_i) |=> (st_q == S_TP));

  p_wr_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |-> (ad_oe_o && !rd_o));

  p_rd_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |-> !ad_oe_o);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_req_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != S_IDLE) && req_i) |=> $stable(addr_q));
endmodule

// File: tb/tb_mbs_seq.sv
module tb_mbs_seq;
  import mbs_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int BUS_W = 16, DATA_W = 8, WAIT_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_i = 0, we_i = 0, lock_n_i = 1, rmt_busy_i = 0, ext_wait_i = 0;
  logic [BUS_W-1:0] addr_i = '0, ad_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [WAIT_W-1:0] pwait_i = '0;
  logic ale_o, ad_oe_o, wr_o, rd_o, done_o;
  logic [BUS_W-1:0] ad_o;
  logic [DATA_W-1:0] rdata_o;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbs_seq #(.BUS_W(BUS_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .pwait_i(pwait_i), .lock_n_i(lock_n_i),
    .rmt_busy_i(rmt_busy_i), .ext_wait_i(ext_wait_i), .ad_i(ad_i),
    .ale_o(ale_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .wr_o(wr_o), .rd_o(rd_o),
    .done_o(done_o), .rdata_o(rdata_o));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One access. k/r/x: number of clocks from accept during which lock low,
  // remote busy high, external wait high. mid_req raises a second request.
  task automatic run_access(input bit we, input int addr, input int wd,
                            input int pw, input int k, input int r,
                            input int x, input int rdv, input bit mid_req);
    int n_tw, n_tp, done_c, ale_n, early_oe, addr_c, data_c, wr_c, wr_first;
    int rd_c, last_ale, extra_ale;
    n_tw = ((k + 1) / 2 > (r + 1) / 2) ? (k + 1) / 2 : (r + 1) / 2;
    n_tp = pw;
    while (2 * n_tw + 4 + 2 * n_tp <= x) n_tp++;
    done_c = 0; ale_n = 0; early_oe = 0; addr_c = 0; data_c = 0;
    wr_c = 0; wr_first = 0; rd_c = 0; last_ale = 0; extra_ale = 0;

    @(posedge clk); #1;
    req_i = 1; we_i = we; addr_i = addr[BUS_W-1:0]; wdata_i = wd[DATA_W-1:0];
    pwait_i = pw[WAIT_W-1:0]; ad_i = rdv[BUS_W-1:0];
    for (int c = 1; c <= 120; c++) begin
      @(posedge clk); #1;
      req_i = mid_req && (c == 4);
      addr_i = 16'hDEAD;
      lock_n_i = !(c <= k); rmt_busy_i = (c <= r); ext_wait_i = (c <= x);
      @(negedge clk);
      if (ale_o) begin ale_n++; last_ale = c; end
      if (ale_o && done_c != 0) extra_ale++;
      if (ad_oe_o && c < 3 + 2 * n_tw) early_oe++;
      if (ad_oe_o && ad_o == addr[BUS_W-1:0]) addr_c++;
      if (ad_oe_o && ad_o == BUS_W'(wd[DATA_W-1:0]) && c >= 5 + 2 * n_tw) data_c++;
      if (wr_o) begin wr_c++; if (wr_first == 0) wr_first = c; end
      if (rd_o) rd_c++;
      if (done_o && done_c == 0) done_c = c;
      if (done_c != 0 && c >= done_c + 6) break;
    end
    lock_n_i = 1; rmt_busy_i = 0; ext_wait_i = 0;
    check("R2 done clock", done_c, f_done_cycle(n_tw, n_tp));
    check("R3 ale high clocks (TW count)", ale_n, 3 + 2 * n_tw);
    check("R5 ale falls mid TX", last_ale, 3 + 2 * n_tw);
    check("R4 bus quiet in T1/TW", early_oe, 0);
    check("R5 address clocks", addr_c, 2);
    check("R10 no second access", extra_ale, 0);
    if (we) begin
      check("R8 write strobe clocks", wr_c, 2);
      check("R6 R7 write strobe start", wr_first, 5 + 2 * n_tw + 2 * n_tp);
      check("R8 write data clocks", data_c, 2 * n_tp + 2);
    end else begin
      check("R9 read strobe clocks", rd_c, 2);
      check("R9 read data", int'(rdata_o), rdv & 8'hFF);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 ale", ale_o, 0);
    check("R1 wr/rd", wr_o | rd_o, 0);
    check("R1 done", done_o, 0);
    check("R1 oe", ad_oe_o, 0);
  endtask

  task automatic t_done_pulse();
    int hi = 0;
    run_access(1, 16'h1111, 8'h22, 0, 0, 0, 0, 0, 0);
    for (int c = 0; c < 4; c++) begin @(negedge clk); hi += done_o; end
    check("R10 done after idle", hi, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    run_access(1, 16'h1234, 8'h5A, 0, 0, 0, 0, 0, 0);   // R2 plain write
    run_access(0, 16'h4321, 0, 0, 0, 0, 0, 16'h00C3, 0); // R9 plain read
    run_access(1, 16'h0F0F, 8'hA5, 0, 1, 0, 0, 0, 0);   // R3 one TW
    run_access(1, 16'h0AB0, 8'h3C, 0, 5, 0, 0, 0, 0);   // R3 three TW
    run_access(0, 16'h0ABC, 0, 0, 0, 4, 0, 16'h0077, 0); // R3 remote busy
    run_access(1, 16'h2222, 8'h81, 3, 0, 0, 0, 0, 0);   // R6 programmed
    run_access(1, 16'h3333, 8'h42, 7, 2, 0, 0, 0, 0);   // R6 max + lock
    run_access(1, 16'h4444, 8'h24, 0, 0, 0, 8, 0, 0);   // R7 external
    run_access(0, 16'h5555, 0, 2, 3, 1, 14, 16'h00E1, 0); // R7 combined
    run_access(1, 16'h6666, 8'h99, 1, 0, 0, 0, 0, 1);   // R10 mid req
    t_done_pulse();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule